// File: doc/BRIEF.md
# Serial Link Receive Synchronization Controller

This block brings up the receive side of one lane of a JESD204B-style serial link. Each clock it takes one decoded lane word: four octets, a control-character flag per octet and a valid qualifier per octet. Octet lane 0 (bits 7:0) is the earliest octet in time. Once the transceiver reports ready, the block drives its active-low synchronization request low. It then counts K28.5 comma characters (octet 0xBC with its control flag set). When enough commas have arrived it releases the request.

After that it checks an alignment sequence of exactly four multiframes. It marks where each multiframe begins and then enters the data phase. In the data phase it forwards words re-aligned so that the first octet after the final multiframe end sits in lane 0.

A coded 2-bit link state tells the rest of the receiver where the bring-up stands: 00 waiting, 01 comma synchronization, 10 alignment check, 11 data. Any failure of the alignment sequence sends the link back to comma synchronization with the request reasserted. Loss of transceiver readiness sends it back to waiting.

Top module: `link_sync_ctrl`

## Requirements
- R1: While `rst_n` is low, `sync_req_n` is 1, `char_err` is 0, `link_state` is 00, `mf_start` is 0, `data_valid` is 0 and `data_out` is 0.
- R2: With `xcvr_ready` low the link stays in state 00 with `sync_req_n` high. One cycle after `xcvr_ready` is seen high in state 00, the state is 01 and `sync_req_n` is low.
- R3: In state 01, a word holding any valid octet that is not a comma (0xBC with control flag 1) raises `char_err` for the following cycle. It also restarts the comma count from zero.
- R4: Once at least 4 commas have been counted since the last restart, with none erroneous in the completing word, the next cycle shows state 10 and `sync_req_n` high.
- R5: In state 10 the block expects four multiframes. Each is opened by K28.0 (0x1C, control 1) and closed by K28.3 (0x7C, control 1), scanned from lane 0 to lane 3. A close and the next open may share one word. Comma octets are tolerated only before the first open.
- R6: The opens must fall in lanes 3, 1, 3, 1 in that order. `mf_start` shows, one cycle after the word, a mask of the lanes where an accepted open occurred (0x8, 0x2, 0x8, 0x2).
- R7: An open in the wrong lane, a stray comma or open inside a multiframe, or a non-open octet while waiting for a later open breaks the sequence. The next cycle then shows state 01 with `sync_req_n` low and `mf_start` 0.
- R8: One cycle after the word carrying the fourth close, the state is 11.
- R9: In state 11, a word with all four octets valid yields, one cycle later, `data_valid` 1 and `data_out` equal to 32 bits of the stream starting at the octet after the final close. Otherwise `data_valid` and `data_out` are 0.
- R10: If `xcvr_ready` is low at a clock edge, in any state, the next cycle shows state 00 and `sync_req_n` high.
- R11: Octets whose valid bit is 0 are skipped by comma counting, error detection and multiframe scanning. They do not count, cannot raise `char_err` and cannot break the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xcvr_ready | input | 1 | Transceiver initialized and delivering words |
| lane_data | input | 32 | Four decoded octets, lane 0 in bits 7:0 and earliest |
| lane_ctrl | input | 4 | Control-character flag per octet |
| lane_valid | input | 4 | Valid qualifier per octet |
| sync_req_n | output | 1 | Active-low synchronization request |
| char_err | output | 1 | Unexpected character seen during comma synchronization |
| link_state | output | 2 | 00 wait, 01 comma sync, 10 alignment, 11 data |
| mf_start | output | 4 | Lanes in which an accepted multiframe open arrived |
| data_out | output | 32 | Frame-aligned data in the data phase |
| data_valid | output | 1 | `data_out` holds a data word |

## Verification
Two functions fall in the same cycle when one word closes a multiframe and opens the next. The alignment words place K28.3 in lane 0 or 2 with K28.0 directly after it. The bench judges this by the `mf_start` mask and by the multiframe count still advancing correctly. The final close also shares a word with the first data octets, so the entry into data and the alignment offset are judged together through the first `data_out` word. A behavioural model, fed every cycle, predicts all outputs independently and is compared on every clock.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int OCT_W = 8;

  localparam logic [OCT_W-1:0] K_COMMA    = 8'hBC;
  localparam logic [OCT_W-1:0] K_MF_OPEN  = 8'h1C;
  localparam logic [OCT_W-1:0] K_MF_CLOSE = 8'h7C;

  typedef enum logic [1:0] {
    LS_WAIT  = 2'b00,
    LS_COMMA = 2'b01,
    LS_ALIGN = 2'b10,
    LS_DATA  = 2'b11
  } link_st_e;

endpackage

// File: rtl/lsc_rst_sync.sv
module lsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = shift_q[STAGES-1];

endmodule

// File: rtl/lsc_comma_count.sv
module lsc_comma_count #(
  parameter  int LANES   = 4,
  parameter  int CGS_MIN = 4,
  localparam int CNT_W   = $clog2(CGS_MIN + LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [LANES-1:0] vld,
  input  logic [LANES-1:0] is_comma,
  output logic             done,
  output logic             err_q
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hits;
  logic [CNT_W-1:0] sum;
  logic             bad;

  // Count commas among valid octets; any other valid octet is an error.
  always_comb begin
    hits = '0;
    bad  = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (vld[i]) begin
        if (is_comma[i]) begin
          hits = hits + CNT_W'(1);
        end else begin
          bad = 1'b1;
        end
      end
    end
    sum = cnt_q + hits;
  end

  assign done = active && !bad && (sum >= CNT_W'(CGS_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= active && bad;
      if (!active || bad) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= sum;
      end
    end
  end

endmodule

// File: rtl/lsc_mf_track.sv
module lsc_mf_track #(
  parameter  int LANES  = 4,
  parameter  int ILA_MF = 4,
  localparam int IDX_W  = $clog2(ILA_MF + 1),
  localparam int OFF_W  = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [LANES-1:0] vld,
  input  logic [LANES-1:0] is_comma,
  input  logic [LANES-1:0] is_open,
  input  logic [LANES-1:0] is_close,
  output logic             brk,
  output logic             fin,
  output logic [LANES-1:0] start_mask,
  output logic [OFF_W-1:0] end_off
);

  logic             open_q, open_w;
  logic [IDX_W-1:0] idx_q, idx_w;
  logic             brk_w, fin_w;
  logic [LANES-1:0] smask_w;
  logic [OFF_W-1:0] off_w;

  // Even-numbered multiframes open in the top lane, odd ones in lane 1.
  function automatic int exp_lane(input logic [IDX_W-1:0] k);
    return k[0] ? 1 : (LANES - 1);
  endfunction

  // Octets are scanned earliest first; a close and the next open may share a word.
  always_comb begin
    open_w  = open_q;
    idx_w   = idx_q;
    brk_w   = 1'b0;
    fin_w   = 1'b0;
    smask_w = '0;
    off_w   = '0;
    for (int i = 0; i < LANES; i++) begin
      if (vld[i] && !fin_w && !brk_w) begin
        if (!open_w) begin
          if (is_open[i]) begin
            if (i == exp_lane(idx_w)) begin
              open_w     = 1'b1;
              smask_w[i] = 1'b1;
            end else begin
              brk_w = 1'b1;
            end
          end else if (!((idx_w == '0) && is_comma[i])) begin
            brk_w = 1'b1;
          end
        end else begin
          if (is_close[i]) begin
            open_w = 1'b0;
            idx_w  = idx_w + IDX_W'(1);
            if (idx_w == IDX_W'(ILA_MF)) begin
              fin_w = 1'b1;
              off_w = OFF_W'(i + 1);
            end
          end else if (is_open[i] || is_comma[i]) begin
            brk_w = 1'b1;
          end
        end
      end
    end
  end

  assign brk        = active && brk_w;
  assign fin        = active && fin_w && !brk_w;
  assign start_mask = (active && !brk_w) ? smask_w : '0;
  assign end_off    = off_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      idx_q  <= '0;
    end else if (!active || brk_w) begin
      open_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      open_q <= open_w;
      idx_q  <= idx_w;
    end
  end

endmodule

// File: rtl/lsc_align.sv
module lsc_align
  import lsc_pkg::*;
#(
  parameter  int LANES = 4,
  localparam int DW    = LANES * OCT_W,
  localparam int OFF_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DW-1:0]    lane_data,
  input  logic [LANES-1:0] lane_valid,
  input  logic             off_load,
  input  logic [OFF_W-1:0] off_in,
  output logic [DW-1:0]    data_out,
  output logic             data_valid
);

  logic [DW-1:0]   prev_q;
  logic [OFF_W-1:0] off_q;
  logic [2*DW-1:0] cat;
  logic [2*DW-1:0] shifted;
  logic            full;
  logic            take;

  assign full    = &lane_valid;
  assign take    = en && full;
  assign cat     = {lane_data, prev_q};
  assign shifted = cat >> (int'(off_q) * OCT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (full) begin
      prev_q <= lane_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_load) begin
      off_q <= off_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out   <= '0;
      data_valid <= 1'b0;
    end else begin
      data_valid <= take;
      data_out   <= take ? shifted[DW-1:0] : '0;
    end
  end

endmodule

// File: rtl/link_sync_ctrl.sv
module link_sync_ctrl
  import lsc_pkg::*;
#(
  parameter  int LANES   = 4,
  parameter  int CGS_MIN = 4,
  parameter  int ILA_MF  = 4,
  localparam int DW      = LANES * OCT_W,
  localparam int OFF_W   = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xcvr_ready,
  input  logic [DW-1:0]    lane_data,
  input  logic [LANES-1:0] lane_ctrl,
  input  logic [LANES-1:0] lane_valid,
  output logic             sync_req_n,
  output logic             char_err,
  output logic [1:0]       link_state,
  output logic [LANES-1:0] mf_start,
  output logic [DW-1:0]    data_out,
  output logic             data_valid
);

  logic             rst_i;
  logic [LANES-1:0] is_comma, is_open, is_close;
  link_st_e         st_q, st_d;
  logic             comma_act, align_act, data_act;
  logic             comma_done;
  logic             mf_brk, mf_fin;
  logic [LANES-1:0] smask;
  logic [OFF_W-1:0] end_off;
  logic             sync_q;
  logic [LANES-1:0] mfs_q;

  lsc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_oct
    logic [OCT_W-1:0] oc;
    assign oc          = lane_data[g*OCT_W +: OCT_W];
    assign is_comma[g] = lane_ctrl[g] && (oc == K_COMMA);
    assign is_open[g]  = lane_ctrl[g] && (oc == K_MF_OPEN);
    assign is_close[g] = lane_ctrl[g] && (oc == K_MF_CLOSE);
  end

  assign comma_act = xcvr_ready && (st_q == LS_COMMA);
  assign align_act = xcvr_ready && (st_q == LS_ALIGN);
  assign data_act  = xcvr_ready && (st_q == LS_DATA);

  lsc_comma_count #(.LANES(LANES), .CGS_MIN(CGS_MIN)) u_comma (
    .clk      (clk),
    .rst_n    (rst_i),
    .active   (comma_act),
    .vld      (lane_valid),
    .is_comma (is_comma),
    .done     (comma_done),
    .err_q    (char_err)
  );

  lsc_mf_track #(.LANES(LANES), .ILA_MF(ILA_MF)) u_mf (
    .clk        (clk),
    .rst_n      (rst_i),
    .active     (align_act),
    .vld        (lane_valid),
    .is_comma   (is_comma),
    .is_open    (is_open),
    .is_close   (is_close),
    .brk        (mf_brk),
    .fin        (mf_fin),
    .start_mask (smask),
    .end_off    (end_off)
  );

  lsc_align #(.LANES(LANES)) u_aln (
    .clk        (clk),
    .rst_n      (rst_i),
    .en         (data_act),
    .lane_data  (lane_data),
    .lane_valid (lane_valid),
    .off_load   (mf_fin),
    .off_in     (end_off),
    .data_out   (data_out),
    .data_valid (data_valid)
  );

  always_comb begin
    st_d = st_q;
    if (!xcvr_ready) begin
      st_d = LS_WAIT;
    end else begin
      case (st_q)
        LS_WAIT:  st_d = LS_COMMA;
        LS_COMMA: if (comma_done) st_d = LS_ALIGN;
        LS_ALIGN: begin
          if (mf_brk)      st_d = LS_COMMA;
          else if (mf_fin) st_d = LS_DATA;
        end
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= LS_WAIT;
      sync_q <= 1'b1;
      mfs_q  <= '0;
    end else begin
      st_q   <= st_d;
      sync_q <= (st_d != LS_COMMA);
      mfs_q  <= smask;
    end
  end

  assign link_state = st_q;
  assign sync_req_n = sync_q;
  assign mf_start   = mfs_q;

endmodule

// File: rtl/lsc_checks.sv
module lsc_checks #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xcvr_ready,
  input logic             sync_req_n,
  input logic             char_err,
  input logic [1:0]       link_state,
  input logic [LANES-1:0] mf_start,
  input logic             data_valid
);

  localparam logic [LANES-1:0] OPEN_LANES = (LANES'(1) << (LANES - 1)) | LANES'(2);

  assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_ready |=> (link_state == 2'b00 && sync_req_n));

  assert_req_on_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'b01 && $past(link_state) == 2'b00) |-> !sync_req_n);

  assert_err_in_comma_R3: assert property (@(posedge clk) disable iff (!rst_n)
    char_err |-> $past(link_state) == 2'b01);

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'b10 && $past(link_state) == 2'b01) |-> sync_req_n);

  assert_mf_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_start & ~OPEN_LANES) == '0);

  assert_mf_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_start != '0) |-> $past(link_state) == 2'b10);

  assert_data_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'b11 && $past(link_state) != 2'b11) |-> $past(link_state) == 2'b10);

  assert_valid_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(link_state) == 2'b11);

endmodule

bind link_sync_ctrl lsc_checks #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xcvr_ready (xcvr_ready),
  .sync_req_n (sync_req_n),
  .char_err   (char_err),
  .link_state (link_state),
  .mf_start   (mf_start),
  .data_valid (data_valid)
);

// File: tb/tb_link_sync_ctrl.sv
module tb_link_sync_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xcvr_ready;
  logic [31:0] lane_data;
  logic [3:0]  lane_ctrl;
  logic [3:0]  lane_valid;
  logic        sync_req_n;
  logic        char_err;
  logic [1:0]  link_state;
  logic [3:0]  mf_start;
  logic [31:0] data_out;
  logic        data_valid;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  link_sync_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .xcvr_ready (xcvr_ready),
    .lane_data  (lane_data),
    .lane_ctrl  (lane_ctrl),
    .lane_valid (lane_valid),
    .sync_req_n (sync_req_n),
    .char_err   (char_err),
    .link_state (link_state),
    .mf_start   (mf_start),
    .data_out   (data_out),
    .data_valid (data_valid)
  );

  // Behavioural reference model.
  int          m_st;
  int          m_cnt;
  bit          m_open;
  int          m_ends;
  int          m_off;
  int          m_exp[$];
  logic [31:0] m_prev;
  logic        e_sync, e_err, e_dv;
  logic [3:0]  e_somf;
  logic [31:0] e_data;

  function automatic bit is_k(input int i, input logic [7:0] v);
    return lane_ctrl[i] && (lane_data[8*i +: 8] == v);
  endfunction

  task automatic mreset();
    m_st = 0; m_cnt = 0; m_open = 0; m_ends = 0; m_off = 0;
    m_exp = '{3, 1, 3, 1}; m_prev = '0;
    e_sync = 1; e_err = 0; e_dv = 0; e_somf = 0; e_data = 0;
  endtask

  task automatic mstep();
    int nxt;
    int n;
    bit err, brk, fin, rdy;
    logic [3:0]  smask;
    logic [63:0] cat;
    rdy  = xcvr_ready;
    cat  = {lane_data, m_prev};
    e_dv = (m_st == 3) && rdy && (lane_valid == 4'hF);
    e_data = e_dv ? cat[8*m_off +: 32] : 32'h0;
    if (lane_valid == 4'hF) m_prev = lane_data;
    err = 0; n = 0; brk = 0; fin = 0; smask = 0;
    if (m_st == 1 && rdy) begin
      for (int i = 0; i < 4; i++) begin
        if (lane_valid[i]) begin
          if (is_k(i, 8'hBC)) n++;
          else err = 1;
        end
      end
      if (err) m_cnt = 0;
      else m_cnt += n;
    end else begin
      m_cnt = 0;
    end
    e_err = err;
    if (m_st == 2 && rdy) begin
      for (int i = 0; i < 4; i++) begin
        if (lane_valid[i] && !fin && !brk) begin
          if (!m_open) begin
            if (is_k(i, 8'h1C)) begin
              if (i == m_exp[0]) begin
                void'(m_exp.pop_front());
                m_open = 1;
                smask[i] = 1'b1;
              end else brk = 1;
            end else if (!(m_ends == 0 && is_k(i, 8'hBC))) brk = 1;
          end else begin
            if (is_k(i, 8'h7C)) begin
              m_open = 0;
              m_ends++;
              if (m_ends == 4) begin fin = 1; m_off = i + 1; end
            end else if (is_k(i, 8'h1C) || is_k(i, 8'hBC)) brk = 1;
          end
        end
      end
    end
    e_somf = brk ? 4'h0 : smask;
    nxt = m_st;
    if (!rdy) nxt = 0;
    else begin
      case (m_st)
        0: nxt = 1;
        1: if (!err && m_cnt >= 4) nxt = 2;
        2: if (brk) nxt = 1; else if (fin) nxt = 3;
        default: nxt = m_st;
      endcase
    end
    if (nxt != 2 || brk) begin
      m_exp = '{3, 1, 3, 1}; m_open = 0; m_ends = 0;
    end
    m_st   = nxt;
    e_sync = (nxt != 1);
  endtask

  initial mreset();

  always @(posedge clk) begin
    if (!rst_n) mreset();
    else mstep();
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare every output against the model on every clock.
  always @(negedge clk) begin
    if (!ended) begin
      chk("R4", "sync_req_n", 32'(sync_req_n), 32'(e_sync));
      chk("R3", "char_err",   32'(char_err),   32'(e_err));
      chk("R5", "link_state", 32'(link_state), 32'(m_st));
      chk("R6", "mf_start",   32'(mf_start),   32'(e_somf));
      chk("R9", "data_valid", 32'(data_valid), 32'(e_dv));
      chk("R9", "data_out",   data_out,        e_data);
    end
  end

  task automatic summary();
    ended = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !ended) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<5000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic send(input logic [31:0] d, input logic [3:0] c, input logic [3:0] v);
    lane_data  = d;
    lane_ctrl  = c;
    lane_valid = v;
    @(negedge clk);
  endtask

  task automatic send_align_start();
    send(32'h1CBCBCBC, 4'b1111, 4'hF);
    chk("R6", "mf0 lane", 32'(mf_start), 32'h8);
    send(32'h22111C7C, 4'b0011, 4'hF);
    chk("R5", "close+open word", 32'(mf_start), 32'h2);
    send(32'h1C7C3344, 4'b1100, 4'hF);
    chk("R6", "mf2 lane", 32'(mf_start), 32'h8);
    send(32'h66551C7C, 4'b0011, 4'hF);
    chk("R6", "mf3 lane", 32'(mf_start), 32'h2);
    chk("R5", "still aligning", 32'(link_state), 32'h2);
  endtask

  initial begin
    rst_n = 0; xcvr_ready = 0;
    lane_data = '0; lane_ctrl = '0; lane_valid = '0;
    repeat (4) @(negedge clk);
    chk("R1", "sync_req_n", 32'(sync_req_n), 32'h1);
    chk("R1", "char_err",   32'(char_err),   32'h0);
    chk("R1", "link_state", 32'(link_state), 32'h0);
    chk("R1", "mf_start",   32'(mf_start),   32'h0);
    chk("R1", "data_valid", 32'(data_valid), 32'h0);
    chk("R1", "data_out",   data_out,        32'h0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk("R2", "wait state", 32'(link_state), 32'h0);
    chk("R2", "no request", 32'(sync_req_n), 32'h1);
    xcvr_ready = 1;
    @(negedge clk);
    chk("R2", "comma state", 32'(link_state), 32'h1);
    chk("R2", "request", 32'(sync_req_n), 32'h0);

    // Three commas plus 0xBC without control flag: error.
    send(32'hBCBCBCBC, 4'b1011, 4'hF);
    chk("R3", "char_err", 32'(char_err), 32'h1);
    send(32'h55BCBCBC, 4'b0111, 4'b0111);
    chk("R11", "invalid octet ignored", 32'(char_err), 32'h0);
    chk("R3", "count restarted", 32'(link_state), 32'h1);
    send(32'h000000BC, 4'b0001, 4'b0001);
    chk("R4", "align state", 32'(link_state), 32'h2);
    chk("R4", "request released", 32'(sync_req_n), 32'h1);

    send_align_start();
    send(32'hA2A17C77, 4'b0010, 4'hF);
    chk("R8", "data state", 32'(link_state), 32'h3);
    send(32'h04030201, 4'b0000, 4'hF);
    chk("R9", "first aligned", data_out, 32'h0201A2A1);
    chk("R9", "valid", 32'(data_valid), 32'h1);
    send(32'h08070605, 4'b0000, 4'hF);
    chk("R9", "second aligned", data_out, 32'h06050403);
    send(32'hFFFFFFFF, 4'b0000, 4'b1110);
    chk("R11", "partial word not valid", 32'(data_valid), 32'h0);
    send(32'h0C0B0A09, 4'b0000, 4'hF);
    chk("R9", "after partial", data_out, 32'h0A090807);

    xcvr_ready = 0;
    @(negedge clk);
    chk("R10", "back to wait", 32'(link_state), 32'h0);
    chk("R10", "request high", 32'(sync_req_n), 32'h1);
    xcvr_ready = 1;
    @(negedge clk);
    chk("R2", "comma again", 32'(link_state), 32'h1);
    send(32'hBCBCBCBC, 4'hF, 4'hF);
    chk("R4", "align again", 32'(link_state), 32'h2);
    send(32'hBCBCBC1C, 4'hF, 4'hF);
    chk("R7", "break to comma", 32'(link_state), 32'h1);
    chk("R7", "request reasserted", 32'(sync_req_n), 32'h0);
    chk("R7", "no start mark", 32'(mf_start), 32'h0);
    send(32'hBCBCBCBC, 4'hF, 4'hF);
    chk("R4", "align third", 32'(link_state), 32'h2);
    send_align_start();
    send(32'h7C939291, 4'b1000, 4'hF);
    chk("R8", "data state", 32'(link_state), 32'h3);
    send(32'hDEADBEEF, 4'b0000, 4'hF);
    chk("R9", "word-aligned data", data_out, 32'hDEADBEEF);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule